// File: doc/BRIEF.md
# Deferred-Context Fault Escalation Unit

This unit decides what happens to a fault raised while the processor is still lazily saving floating-point state for an interrupted context. The decision does not use the live core state. It uses a set of ready flags that were captured together with that context: one copy per security bank, and a few flags that exist only in the secure copy. Depending on those flags, a request is dropped, pended on its own vector, or escalated to the hard-fault vector. Escalation also raises a forced-escalation status pulse. If the chosen target could not pre-empt the current execution priority, and the saved context does not allow hard-fault entry, the unit declares lockup.

Beside the request path, the unit answers a one-cycle "ready" query. The query reports whether a named exception is enabled and urgent enough to interrupt the current execution priority. Priorities are signed 9-bit values, so the fixed-priority exceptions can sit at -1, -2 and -3. Group priority is taken from a vector's priority by clearing its low `prigroup` bits. Both paths are a single register stage: inputs in cycle t give outputs in cycle t+1.

Top module: `deferred_ctx_escalator`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs are cleared at that edge: no pend pulse, no forced pulse, `lockup` low, `q_ready` low.
- R2: Request number 12 (debug monitor) is dropped, with no pend, no forced pulse and no lockup, when bit 5 of `rdy_sec` is 0. When that bit is 1, the request pends vector 12 in the shared table (bank 0) without escalation.
- R3: Request numbers 4 (memory management) and 6 (usage) escalate when their ready bit in the copy for `req_bank_sec` is 0. In the secure copy these are bits 1 and 3 of `rdy_sec`. In the non-secure copy they are bits 0 and 1 of `rdy_ns`. Without escalation they pend their own vector in bank `req_bank_sec`.
- R4: Request numbers 5 (bus) and 7 (security) escalate when bit 2 or bit 4 of `rdy_sec`, respectively, is 0, regardless of bank. Without escalation they pend their own vector in bank 0.
- R5: An escalated request targets vector 3 (hard fault). It uses the secure bank when `sec_ext` is 1 and either the original fault targeted secure or `faults_ns` is 0; otherwise it uses bank 0. The original fault targets secure when `req_bank_sec` is set for numbers 4 and 6, and when `req_tgt_sec` is set for numbers 5 and 7. Every escalation gives a one-cycle `forced_pulse`.
- R6: `pend_pulse` is a one-cycle pulse, one cycle after the request, that carries the target in `pend_exc`/`pend_bank_sec`. It fires only when the target vector's pending bit in the selected bank is 0.
- R7: For a request that is not dropped, `lockup` rises when bit 0 of `rdy_sec` is 0 and either the target vector is disabled or `exec_prio` is less than or equal to its group priority (signed). Once high, `lockup` stays high until reset.
- R8: A query for number 3 returns `q_ready` = 1 exactly when `exec_prio` > -1. Enable and priority tables are ignored for this query.
- R9: A query for any other number returns enabled AND group priority < `exec_prio` (signed). The query reads bank `q_bank_sec` for numbers 4 and 6, and bank 0 for all other numbers.
- R10: Group priority equals the vector priority with the low `prigroup` bits cleared when the priority is non-negative. A negative priority is used unchanged.
- R11: Any request number other than 4, 5, 6, 7 and 12 is ignored: no pend, no forced pulse, no lockup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A fault request is present this cycle |
| req_exc | input | EXC_W | Requested exception number |
| req_bank_sec | input | 1 | Bank select for banked exceptions |
| req_tgt_sec | input | 1 | Non-banked fault originally targets secure |
| rdy_sec | input | 6 | Saved ready flags, secure copy |
| rdy_ns | input | 2 | Saved ready flags, non-secure copy |
| sec_ext | input | 1 | Security extension is present |
| faults_ns | input | 1 | Control bit that routes faults to non-secure |
| exec_prio | input | PRIO_W | Current execution priority (signed) |
| prigroup | input | GRP_W | Number of sub-priority bits to clear |
| en_s | input | NUM_VEC | Vector enables, secure bank |
| en_ns | input | NUM_VEC | Vector enables, bank 0 |
| prio_s | input | NUM_VEC*PRIO_W | Vector priorities, secure bank |
| prio_ns | input | NUM_VEC*PRIO_W | Vector priorities, bank 0 |
| pend_s | input | NUM_VEC | Pending bits, secure bank |
| pend_ns | input | NUM_VEC | Pending bits, bank 0 |
| q_exc | input | EXC_W | Exception number for the ready query |
| q_bank_sec | input | 1 | Bank select for the ready query |
| pend_pulse | output | 1 | Set the pending bit of the target vector |
| pend_exc | output | EXC_W | Target vector number |
| pend_bank_sec | output | 1 | Target bank |
| forced_pulse | output | 1 | Set the forced-escalation status bit |
| lockup | output | 1 | Sticky lockup indication |
| q_ready | output | 1 | Ready query result |

## Verification
The bench aims at the bank-selection corners. A memory or usage fault must read the copy for its own bank, while bus and security faults must read the secure copy only. A design that mixes these up escalates on the wrong flag. The escalated hard-fault bank depends on three inputs; a wrong rule sends `pend_bank_sec` to the wrong table. The bench holds targets that are already pending, where a wrong design would pulse anyway. It drives `exec_prio` equal to a group priority, where an off-by-one compare either misses lockup or reports it falsely. It drives negative priorities and the hard-fault query, which must ignore the enable tables and use the fixed -1 threshold.

// File: rtl/dce_pkg.sv
package dce_pkg;
  // saved ready flag positions, secure copy
  localparam int RB_HARD  = 0;
  localparam int RB_MEM   = 1;
  localparam int RB_BUS   = 2;
  localparam int RB_USAGE = 3;
  localparam int RB_SECF  = 4;
  localparam int RB_MON   = 5;
  localparam int RDY_W    = 6;
  // non-secure copy carries only the banked faults
  localparam int NB_MEM   = 0;
  localparam int NB_USAGE = 1;
  localparam int RDYN_W   = 2;

  localparam int EXC_HARD  = 3;
  localparam int EXC_MEM   = 4;
  localparam int EXC_BUS   = 5;
  localparam int EXC_USAGE = 6;
  localparam int EXC_SECF  = 7;
  localparam int EXC_MON   = 12;

  typedef enum logic [2:0] {
    K_NONE, K_MON, K_MEM, K_USAGE, K_BUS, K_SECF
  } kind_e;

  function automatic kind_e kind_of(input logic [31:0] n);
    case (n)
      EXC_MON:   return K_MON;
      EXC_MEM:   return K_MEM;
      EXC_USAGE: return K_USAGE;
      EXC_BUS:   return K_BUS;
      EXC_SECF:  return K_SECF;
      default:   return K_NONE;
    endcase
  endfunction
endpackage

// File: rtl/dce_classify.sv
module dce_classify
  import dce_pkg::*;
#(
  parameter int EXC_W = 4
) (
  input  logic [EXC_W-1:0]  exc,
  input  logic              bank_sec,
  input  logic              tgt_sec,
  input  logic [RDY_W-1:0]  rdy_s,
  input  logic [RDYN_W-1:0] rdy_n,
  input  logic              sec_ext,
  input  logic              faults_ns,
  output logic              drop,
  output logic              esc,
  output logic [EXC_W-1:0]  t_exc,
  output logic              t_sec
);
  kind_e kind;
  logic  banked;
  logic  orig_sec;

  always_comb begin
    kind   = kind_of(32'(exc));
    drop   = 1'b0;
    esc    = 1'b0;
    banked = 1'b0;
    case (kind)
      K_MON:   drop = !rdy_s[RB_MON];
      K_MEM:   begin
        banked = 1'b1;
        esc    = bank_sec ? !rdy_s[RB_MEM] : !rdy_n[NB_MEM];
      end
      K_USAGE: begin
        banked = 1'b1;
        esc    = bank_sec ? !rdy_s[RB_USAGE] : !rdy_n[NB_USAGE];
      end
      K_BUS:   esc  = !rdy_s[RB_BUS];
      K_SECF:  esc  = !rdy_s[RB_SECF];
      default: drop = 1'b1;
    endcase
    orig_sec = banked ? bank_sec : tgt_sec;
    if (esc) begin
      t_exc = EXC_W'(EXC_HARD);
      t_sec = sec_ext && (orig_sec || !faults_ns);
    end else begin
      t_exc = exc;
      t_sec = banked && bank_sec;
    end
  end
endmodule

// File: rtl/dce_vec_lookup.sv
module dce_vec_lookup #(
  parameter int NUM_VEC = 16,
  parameter int PRIO_W  = 9,
  parameter int GRP_W   = 3,
  localparam int EXC_W  = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0]        en_s,
  input  logic [NUM_VEC-1:0]        en_ns,
  input  logic [NUM_VEC*PRIO_W-1:0] prio_s,
  input  logic [NUM_VEC*PRIO_W-1:0] prio_ns,
  input  logic [EXC_W-1:0]          idx,
  input  logic                      sec,
  input  logic [GRP_W-1:0]          prigroup,
  output logic                      en,
  output logic signed [PRIO_W-1:0]  grp
);
  logic [PRIO_W-1:0] pr_s  [NUM_VEC];
  logic [PRIO_W-1:0] pr_ns [NUM_VEC];

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_unpack
    assign pr_s[i]  = prio_s[i*PRIO_W +: PRIO_W];
    assign pr_ns[i] = prio_ns[i*PRIO_W +: PRIO_W];
  end

  logic [PRIO_W-1:0] raw;
  logic [PRIO_W-1:0] mask;

  always_comb begin
    raw  = sec ? pr_s[idx] : pr_ns[idx];
    en   = sec ? en_s[idx] : en_ns[idx];
    mask = {PRIO_W{1'b1}} << prigroup;
    grp  = raw[PRIO_W-1] ? $signed(raw) : $signed(raw & mask);
  end
endmodule

// File: rtl/dce_ready_query.sv
module dce_ready_query
  import dce_pkg::*;
#(
  parameter int EXC_W  = 4,
  parameter int PRIO_W = 9
) (
  input  logic [EXC_W-1:0]         q_exc,
  input  logic                     q_bank_sec,
  input  logic                     en,
  input  logic signed [PRIO_W-1:0] grp,
  input  logic signed [PRIO_W-1:0] exec_prio,
  output logic                     l_sec,
  output logic                     ready
);
  logic is_hard;
  logic banked;

  always_comb begin
    is_hard = (q_exc == EXC_W'(EXC_HARD));
    banked  = is_hard || (q_exc == EXC_W'(EXC_MEM)) || (q_exc == EXC_W'(EXC_USAGE));
    l_sec   = banked && q_bank_sec;
    if (is_hard) ready = !exec_prio[PRIO_W-1];
    else         ready = en && (grp < exec_prio);
  end
endmodule

// File: rtl/deferred_ctx_escalator.sv
module deferred_ctx_escalator
  import dce_pkg::*;
#(
  parameter int NUM_VEC = 16,
  parameter int PRIO_W  = 9,
  parameter int GRP_W   = 3,
  localparam int EXC_W  = $clog2(NUM_VEC)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [EXC_W-1:0]          req_exc,
  input  logic                      req_bank_sec,
  input  logic                      req_tgt_sec,
  input  logic [5:0]                rdy_sec,
  input  logic [1:0]                rdy_ns,
  input  logic                      sec_ext,
  input  logic                      faults_ns,
  input  logic signed [PRIO_W-1:0]  exec_prio,
  input  logic [GRP_W-1:0]          prigroup,
  input  logic [NUM_VEC-1:0]        en_s,
  input  logic [NUM_VEC-1:0]        en_ns,
  input  logic [NUM_VEC*PRIO_W-1:0] prio_s,
  input  logic [NUM_VEC*PRIO_W-1:0] prio_ns,
  input  logic [NUM_VEC-1:0]        pend_s,
  input  logic [NUM_VEC-1:0]        pend_ns,
  input  logic [EXC_W-1:0]          q_exc,
  input  logic                      q_bank_sec,
  output logic                      pend_pulse,
  output logic [EXC_W-1:0]          pend_exc,
  output logic                      pend_bank_sec,
  output logic                      forced_pulse,
  output logic                      lockup,
  output logic                      q_ready
);
  logic                     drop, esc, t_sec, t_en, t_pend, lock_cond;
  logic [EXC_W-1:0]         t_exc;
  logic signed [PRIO_W-1:0] t_grp;
  logic                     ql_sec, ql_en, q_ready_c;
  logic signed [PRIO_W-1:0] ql_grp;

  dce_classify #(.EXC_W(EXC_W)) u_cls (
    .exc(req_exc), .bank_sec(req_bank_sec), .tgt_sec(req_tgt_sec),
    .rdy_s(rdy_sec), .rdy_n(rdy_ns), .sec_ext(sec_ext), .faults_ns(faults_ns),
    .drop(drop), .esc(esc), .t_exc(t_exc), .t_sec(t_sec)
  );

  dce_vec_lookup #(.NUM_VEC(NUM_VEC), .PRIO_W(PRIO_W), .GRP_W(GRP_W)) u_tgt (
    .en_s(en_s), .en_ns(en_ns), .prio_s(prio_s), .prio_ns(prio_ns),
    .idx(t_exc), .sec(t_sec), .prigroup(prigroup), .en(t_en), .grp(t_grp)
  );

  dce_vec_lookup #(.NUM_VEC(NUM_VEC), .PRIO_W(PRIO_W), .GRP_W(GRP_W)) u_qry (
    .en_s(en_s), .en_ns(en_ns), .prio_s(prio_s), .prio_ns(prio_ns),
    .idx(q_exc), .sec(ql_sec), .prigroup(prigroup), .en(ql_en), .grp(ql_grp)
  );

  dce_ready_query #(.EXC_W(EXC_W), .PRIO_W(PRIO_W)) u_rq (
    .q_exc(q_exc), .q_bank_sec(q_bank_sec), .en(ql_en), .grp(ql_grp),
    .exec_prio(exec_prio), .l_sec(ql_sec), .ready(q_ready_c)
  );

  always_comb begin
    t_pend    = t_sec ? pend_s[t_exc] : pend_ns[t_exc];
    lock_cond = (!t_en || (exec_prio <= t_grp)) && !rdy_sec[RB_HARD];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_pulse    <= 1'b0;
      pend_exc      <= '0;
      pend_bank_sec <= 1'b0;
      forced_pulse  <= 1'b0;
      lockup        <= 1'b0;
      q_ready       <= 1'b0;
    end else begin
      pend_pulse    <= req_valid && !drop && !t_pend;
      pend_exc      <= t_exc;
      pend_bank_sec <= t_sec;
      forced_pulse  <= req_valid && !drop && esc;
      if (req_valid && !drop && lock_cond) lockup <= 1'b1;
      q_ready       <= q_ready_c;
    end
  end
endmodule

// File: rtl/dce_checker.sv
module dce_checker
  import dce_pkg::*;
#(
  parameter int NUM_VEC = 16,
  parameter int PRIO_W  = 9,
  localparam int EXC_W  = $clog2(NUM_VEC)
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     req_valid,
  input logic [EXC_W-1:0]         req_exc,
  input logic                     req_bank_sec,
  input logic [5:0]               rdy_sec,
  input logic [NUM_VEC-1:0]       pend_s,
  input logic [NUM_VEC-1:0]       pend_ns,
  input logic signed [PRIO_W-1:0] exec_prio,
  input logic [EXC_W-1:0]         q_exc,
  input logic                     pend_pulse,
  input logic [EXC_W-1:0]         pend_exc,
  input logic                     forced_pulse,
  input logic                     lockup,
  input logic                     q_ready
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !lockup && !pend_pulse && !forced_pulse && !q_ready); // R1

  AST_MON_DROP: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_exc == EXC_W'(EXC_MON) && !rdy_sec[RB_MON]
      |=> !pend_pulse && !forced_pulse); // R2

  AST_BUS_ESC: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_exc == EXC_W'(EXC_BUS) && !rdy_sec[RB_BUS] |=> forced_pulse); // R4

  AST_FORCED_TO_HARD: assert property (@(posedge clk) disable iff (rst)
    forced_pulse && pend_pulse |-> pend_exc == EXC_W'(EXC_HARD)); // R5

  AST_NO_REPEND: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_exc == EXC_W'(EXC_MEM) && rdy_sec[RB_MEM] && req_bank_sec
      && pend_s[EXC_MEM] |=> !pend_pulse); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !pend_pulse && !forced_pulse); // R6

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    lockup |=> lockup); // R7

  AST_HARD_QUERY: assert property (@(posedge clk) disable iff (rst)
    q_exc == EXC_W'(EXC_HARD) |=> q_ready == $past(!exec_prio[PRIO_W-1])); // R8

  AST_UNKNOWN_IGNORED: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_exc == EXC_W'(0) |=> !pend_pulse && !forced_pulse
      && (lockup == $past(lockup))); // R11

  logic unused_ok;
  assign unused_ok = ^{pend_ns};
endmodule

bind deferred_ctx_escalator dce_checker #(.NUM_VEC(NUM_VEC), .PRIO_W(PRIO_W)) u_dce_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_exc(req_exc),
  .req_bank_sec(req_bank_sec), .rdy_sec(rdy_sec), .pend_s(pend_s), .pend_ns(pend_ns),
  .exec_prio(exec_prio), .q_exc(q_exc), .pend_pulse(pend_pulse), .pend_exc(pend_exc),
  .forced_pulse(forced_pulse), .lockup(lockup), .q_ready(q_ready)
);

// File: tb/test_deferred_ctx_escalator.sv
`timescale 1ns/1ps
module test_deferred_ctx_escalator;
  localparam int NV = 16;
  localparam int PW = 9;
  localparam int GW = 3;
  localparam int EW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, req_valid, req_bank_sec, req_tgt_sec, sec_ext, faults_ns, q_bank_sec;
  logic [EW-1:0] req_exc, q_exc;
  logic [5:0] rdy_sec;
  logic [1:0] rdy_ns;
  logic signed [PW-1:0] exec_prio;
  logic [GW-1:0] prigroup;
  logic [NV-1:0] en_s, en_ns, pend_s, pend_ns;
  logic [NV*PW-1:0] prio_s, prio_ns;
  logic pend_pulse, pend_bank_sec, forced_pulse, lockup, q_ready;
  logic [EW-1:0] pend_exc;

  deferred_ctx_escalator #(.NUM_VEC(NV), .PRIO_W(PW), .GRP_W(GW)) i_deferred_ctx_escalator (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_exc(req_exc),
    .req_bank_sec(req_bank_sec), .req_tgt_sec(req_tgt_sec), .rdy_sec(rdy_sec),
    .rdy_ns(rdy_ns), .sec_ext(sec_ext), .faults_ns(faults_ns), .exec_prio(exec_prio),
    .prigroup(prigroup), .en_s(en_s), .en_ns(en_ns), .prio_s(prio_s), .prio_ns(prio_ns),
    .pend_s(pend_s), .pend_ns(pend_ns), .q_exc(q_exc), .q_bank_sec(q_bank_sec),
    .pend_pulse(pend_pulse), .pend_exc(pend_exc), .pend_bank_sec(pend_bank_sec),
    .forced_pulse(forced_pulse), .lockup(lockup), .q_ready(q_ready)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // expected values for the next compare
  bit e_valid = 0, e_rst, e_pend, e_bank, e_forced, e_lock = 0, e_q;
  int e_exc;
  string t_pend, t_q;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int grp_of(input int p, input int pg);
    if (p < 0) return p;
    return (p >> pg) << pg;
  endfunction

  function automatic int prio_at(input bit sec, input int i);
    logic [PW-1:0] v;
    v = sec ? prio_s[i*PW +: PW] : prio_ns[i*PW +: PW];
    return int'($signed(v));
  endfunction

  task automatic compare();
    if (e_rst) begin
      chk(!pend_pulse && !forced_pulse && !lockup && !q_ready, "R1 reset", 
          {pend_pulse, forced_pulse, lockup, q_ready}, 0);
      return;
    end
    chk(pend_pulse == e_pend, t_pend, pend_pulse, e_pend);
    if (e_pend) begin
      chk(int'(pend_exc) == e_exc, "R5 target vector", pend_exc, e_exc);
      chk(pend_bank_sec == e_bank, "R5 target bank", pend_bank_sec, e_bank);
    end
    chk(forced_pulse == e_forced, "R5 forced pulse", forced_pulse, e_forced);
    chk(lockup == e_lock, "R7 lockup", lockup, e_lock);
    chk(q_ready == e_q, t_q, q_ready, e_q);
  endtask

  function automatic int pick_exc();
    int tab[8] = '{3, 4, 5, 6, 7, 12, 0, 9};
    return tab[$urandom % 8];
  endfunction

  task automatic drive(input int cyc);
    rst          = (cyc < 2) || (cyc % 40 == 0);
    req_valid    = ($urandom % 4) != 0;
    req_exc      = EW'(pick_exc());
    req_bank_sec = $urandom % 2;
    req_tgt_sec  = $urandom % 2;
    rdy_sec      = 6'($urandom);
    rdy_ns       = 2'($urandom);
    sec_ext      = $urandom % 2;
    faults_ns    = $urandom % 2;
    exec_prio    = PW'(int'($urandom % 70) - 4);
    prigroup     = GW'($urandom % 5);
    for (int i = 0; i < NV; i++) begin
      en_s[i]    = ($urandom % 4) != 0;
      en_ns[i]   = ($urandom % 4) != 0;
      pend_s[i]  = ($urandom % 4) == 0;
      pend_ns[i] = ($urandom % 4) == 0;
      prio_s[i*PW +: PW]  = PW'(int'($urandom % 66) - 3);
      prio_ns[i*PW +: PW] = PW'(int'($urandom % 66) - 3);
    end
    q_exc      = EW'(pick_exc());
    q_bank_sec = $urandom % 2;
  endtask

  task automatic predict();
    int  x, tx, qx, ep, g;
    bit  drop, esc, banked, orig, tsec, ten, tp, qsec;
    e_valid = 1;
    e_rst   = rst;
    if (rst) begin
      e_lock = 0;
      return;
    end
    x = int'(req_exc);
    ep = int'(exec_prio);
    drop = 0; esc = 0; banked = 0;
    if (x == 12) drop = !rdy_sec[5];                                  // R2
    else if (x == 4) begin banked = 1; esc = req_bank_sec ? !rdy_sec[1] : !rdy_ns[0]; end // R3
    else if (x == 6) begin banked = 1; esc = req_bank_sec ? !rdy_sec[3] : !rdy_ns[1]; end // R3
    else if (x == 5) esc = !rdy_sec[2];                                // R4
    else if (x == 7) esc = !rdy_sec[4];                                // R4
    else drop = 1;                                                     // R11
    orig = banked ? req_bank_sec : req_tgt_sec;
    if (esc) begin tx = 3; tsec = sec_ext && (orig || !faults_ns); end
    else begin tx = x; tsec = banked && req_bank_sec; end
    ten = tsec ? en_s[tx] : en_ns[tx];
    tp  = tsec ? pend_s[tx] : pend_ns[tx];
    g   = grp_of(prio_at(tsec, tx), int'(prigroup));                   // R10
    e_pend   = req_valid && !drop && !tp;                              // R6
    e_exc    = tx;
    e_bank   = tsec;
    e_forced = req_valid && !drop && esc;
    if (req_valid && !drop && (!ten || ep <= g) && !rdy_sec[0]) e_lock = 1; // R7
    if (x == 12) t_pend = "R2 R6 pend";
    else if (x == 4 || x == 6) t_pend = "R3 R6 pend";
    else if (x == 5 || x == 7) t_pend = "R4 R6 pend";
    else t_pend = "R11 pend";
    qx = int'(q_exc);
    if (qx == 3) begin
      e_q = ep > -1;                                                   // R8
      t_q = "R8 hard query";
    end else begin
      qsec = (qx == 4 || qx == 6) && q_bank_sec;
      e_q = (qsec ? en_s[qx] : en_ns[qx]) &&
            (grp_of(prio_at(qsec, qx), int'(prigroup)) < ep);          // R9 R10
      t_q = "R9 R10 query";
    end
  endtask

  initial begin
    drive(0);
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      if (e_valid) compare();
      drive(cyc);
      predict();
    end
    @(negedge clk);
    compare();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule